// File: doc/BRIEF.md
# Power-Zone Idle Power Controller

This block governs one independently switchable power zone inside a processor core. It keeps a saturating count of the clock cycles that have passed since the zone was last used, and compares that count against a threshold that software writes. When the count rises strictly above the threshold and nothing is asking for the zone, the block withdraws the zone's power enable. When a use request reaches an unpowered zone, the block restores power by itself. It holds the request off with a ready signal until the power switch reports good supply. At each such wake it keeps a copy of the idle count that had built up.

Software steers the policy only through the threshold. A moderate value gives automatic power-down after that many idle cycles. All ones keeps the zone on, because the saturated count can never exceed it. Zero drops power on the first idle cycle. Any value below the present count forces power-down at once. A privilege input gates all register access.

Top module: `zone_idle_pwr_ctrl`

## Requirements
- R1: The idle count (register address 0, read-only) increments by one on every clock edge on which the zone is not in use. It is zero after every edge on which the zone is powered and ready with `zone_req` high, and it is held at zero from the wake edge until the zone becomes ready.
- R2: The idle count saturates at all ones and never wraps to zero.
- R3: While the zone is ready and `zone_req` is low, `pwr_en` falls one edge after the count becomes strictly greater than the threshold (register address 1). A count equal to the threshold keeps the zone powered.
- R4: With the threshold at all ones, a powered zone is never switched off, however long it stays idle.
- R5: With the threshold at 0, the zone stays powered while `zone_req` is held. After `zone_req` drops, the first idle edge leaves power on and the second idle edge removes it.
- R6: Writing a threshold below the present count removes power on the edge after the write edge.
- R7: A `zone_req` seen while power is off and `pwr_good` is low raises `pwr_en` after the next edge and clears the idle count, with no software action.
- R8: The snapshot register (address 2, read-only) holds the idle count that stood just before the most recent wake edge.
- R9: `zone_rdy` is low from the wake until the edge on which `pwr_good` is seen high, and `zone_rdy` is never high without `pwr_good`.
- R10: After reset `pwr_en` and `zone_rdy` are low, the count and the snapshot read 0, and the threshold reads decimal 10000. Address 3 reads 0.
- R11: While `csr_priv` is low, `csr_rdata` is 0 and writes leave the threshold unchanged.
- R12: Once `pwr_en` has fallen, it stays low for as long as `pwr_good` remains high, even when `zone_req` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| zone_req | input | 1 | The core needs the zone this cycle |
| zone_rdy | output | 1 | Zone powered and usable; a request is stalled while low |
| pwr_en | output | 1 | Registered enable to the zone's power switch |
| pwr_good | input | 1 | Power switch reports the zone supply is valid |
| csr_priv | input | 1 | Access is privileged |
| csr_addr | input | 2 | Register select: 0 count, 1 threshold, 2 snapshot, 3 none |
| csr_wr | input | 1 | Write strobe (only the threshold is writable) |
| csr_wdata | input | CNT_W | Write data |
| csr_rdata | output | CNT_W | Read data, combinational from the address |

## Verification
A count that is cleared or advanced on the wrong edge moves the power-down point. It shows up on `pwr_en` one edge early or late relative to the threshold, and the equality case separates strict from non-strict compare. A state machine that loses its place shows either as `zone_rdy` high before `pwr_good`, or as `pwr_en` rising while the supply from the last shutdown is still good. Both are visible within a few cycles of the wake or shutdown. A wrong snapshot or privilege path shows only on the next register read, so reads are placed right after each wake and each gated access.

// File: rtl/zpc_pkg.sv
package zpc_pkg;

  typedef enum logic [1:0] {
    ZS_OFF  = 2'd0,
    ZS_WAKE = 2'd1,
    ZS_ON   = 2'd2
  } zone_st_e;

  localparam int CSR_AW = 2;
  localparam logic [CSR_AW-1:0] CSR_IDLE = 2'd0;
  localparam logic [CSR_AW-1:0] CSR_THR  = 2'd1;
  localparam logic [CSR_AW-1:0] CSR_SNAP = 2'd2;

endpackage

// File: rtl/zpc_idle_counter.sv
module zpc_idle_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr || (cnt_q != SAT);
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt != SAT) |=> (cnt == $past(cnt) + 1'b1)); // R1

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == SAT) |=> (cnt == SAT)); // R2

endmodule

// File: rtl/zpc_power_fsm.sv
module zpc_power_fsm
  import zpc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zone_req,
  input  logic             pwr_good,
  input  logic [CNT_W-1:0] threshold,
  input  logic [CNT_W-1:0] idle_cnt,
  output logic             pwr_en,
  output logic             zone_rdy,
  output logic             wake,
  output logic             cnt_clr
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  zone_st_e st_q, st_d;
  logic     pwr_en_q, pwr_en_d;
  logic     idle_expired;

  always_comb begin
    idle_expired = threshold < idle_cnt;
    wake         = (st_q == ZS_OFF) && zone_req && !pwr_good;
    st_d         = st_q;
    unique case (st_q)
      ZS_OFF:  if (wake)                         st_d = ZS_WAKE;
      ZS_WAKE: if (pwr_good)                     st_d = ZS_ON;
      ZS_ON:   if (!zone_req && idle_expired)    st_d = ZS_OFF;
      default:                                   st_d = ZS_OFF;
    endcase
    pwr_en_d = (st_d != ZS_OFF);
    cnt_clr  = wake || (st_q == ZS_WAKE) || ((st_q == ZS_ON) && zone_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ZS_OFF;
      pwr_en_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      pwr_en_q <= pwr_en_d;
    end
  end

  assign pwr_en   = pwr_en_q;
  assign zone_rdy = (st_q == ZS_ON);

  AST_RDY_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    zone_rdy |-> pwr_good); // R9

  AST_OFF_ONLY_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(zone_rdy)); // R3

  AST_EXPIRED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (zone_rdy && !zone_req && threshold < idle_cnt) |=> !pwr_en); // R3

  AST_FORCED_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (zone_rdy && threshold == ALL_ONES) |=> pwr_en); // R4

  AST_NO_FAST_REENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && pwr_good) |=> !pwr_en); // R12

  AST_WAKE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (pwr_en && !zone_rdy)); // R7

endmodule

// File: rtl/zpc_regs.sv
module zpc_regs
  import zpc_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int RESET_THRESH = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_priv,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic              csr_wr,
  input  logic [CNT_W-1:0]  csr_wdata,
  output logic [CNT_W-1:0]  csr_rdata,
  input  logic [CNT_W-1:0]  idle_cnt,
  input  logic              snap_load,
  output logic [CNT_W-1:0]  threshold
);

  localparam logic [CNT_W-1:0] THR_RST = CNT_W'(RESET_THRESH);

  logic [CNT_W-1:0] thr_q, thr_d, snap_q;
  logic             thr_en;

  always_comb begin
    thr_en = csr_priv && csr_wr && (csr_addr == CSR_THR);
    thr_d  = csr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= THR_RST;
    else if (thr_en) thr_q <= thr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         snap_q <= '0;
    else if (snap_load) snap_q <= idle_cnt;
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_priv) begin
      unique case (csr_addr)
        CSR_IDLE: csr_rdata = idle_cnt;
        CSR_THR:  csr_rdata = thr_q;
        CSR_SNAP: csr_rdata = snap_q;
        default:  csr_rdata = '0;
      endcase
    end
  end

  assign threshold = thr_q;

  AST_UNPRIV_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !csr_priv) |=> $stable(threshold)); // R11

  AST_SNAPSHOT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_load |=> (csr_priv && csr_addr == CSR_SNAP) ? (csr_rdata == $past(idle_cnt)) : 1'b1); // R8

endmodule

// File: rtl/zone_idle_pwr_ctrl.sv
module zone_idle_pwr_ctrl
  import zpc_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int RESET_THRESH = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zone_req,
  output logic              zone_rdy,
  output logic              pwr_en,
  input  logic              pwr_good,
  input  logic              csr_priv,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic              csr_wr,
  input  logic [CNT_W-1:0]  csr_wdata,
  output logic [CNT_W-1:0]  csr_rdata
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] idle_cnt, threshold;
  logic             wake, cnt_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  zpc_idle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (cnt_clr),
    .cnt   (idle_cnt)
  );

  zpc_power_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .zone_req  (zone_req),
    .pwr_good  (pwr_good),
    .threshold (threshold),
    .idle_cnt  (idle_cnt),
    .pwr_en    (pwr_en),
    .zone_rdy  (zone_rdy),
    .wake      (wake),
    .cnt_clr   (cnt_clr)
  );

  zpc_regs #(.CNT_W(CNT_W), .RESET_THRESH(RESET_THRESH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .csr_priv  (csr_priv),
    .csr_addr  (csr_addr),
    .csr_wr    (csr_wr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .idle_cnt  (idle_cnt),
    .snap_load (wake),
    .threshold (threshold)
  );

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_int_n) |-> (!pwr_en && !zone_rdy)); // R10

endmodule

// File: tb/tb_zone_idle_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_zone_idle_pwr_ctrl;

  localparam int W  = 32;
  localparam int NW = 8;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } sb_item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          zone_req, zone_rdy, pwr_en, pwr_good;
  logic          csr_priv, csr_wr;
  logic [1:0]    csr_addr;
  logic [W-1:0]  csr_wdata, csr_rdata;

  logic          n_req, n_rdy, n_en, n_good;
  logic [1:0]    n_addr;
  logic [NW-1:0] n_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  sb_item_t sbq[$];
  bit pend = 0;
  logic [2:0] pg_sh, npg_sh;

  always #5 clk = ~clk;

  zone_idle_pwr_ctrl #(.CNT_W(W), .RESET_THRESH(10000)) dut (
    .clk(clk), .rst_n(rst_n), .zone_req(zone_req), .zone_rdy(zone_rdy),
    .pwr_en(pwr_en), .pwr_good(pwr_good), .csr_priv(csr_priv),
    .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata));

  zone_idle_pwr_ctrl #(.CNT_W(NW), .RESET_THRESH(255)) dut_narrow (
    .clk(clk), .rst_n(rst_n), .zone_req(n_req), .zone_rdy(n_rdy),
    .pwr_en(n_en), .pwr_good(n_good), .csr_priv(1'b1),
    .csr_addr(n_addr), .csr_wr(1'b0), .csr_wdata('0),
    .csr_rdata(n_rdata));

  // power switch models: supply follows enable after three falling edges
  always @(negedge clk) begin
    if (!rst_n) begin
      pg_sh = '0; npg_sh = '0;
    end else begin
      pg_sh  = {pg_sh[1:0], pwr_en};
      npg_sh = {npg_sh[1:0], n_en};
    end
    pwr_good = pg_sh[2];
    n_good   = npg_sh[2];
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // scoreboard driver: present a read, queue the expected data
  task automatic do_read(logic [1:0] a, logic pv, logic [W-1:0] exp, string tag);
    sb_item_t it;
    csr_addr = a; csr_priv = pv;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    pend = 1;
    tick();
    csr_priv = 1'b1;
  endtask

  task automatic do_write(logic [1:0] a, logic [W-1:0] d, logic pv);
    csr_addr = a; csr_wdata = d; csr_priv = pv; csr_wr = 1'b1;
    tick();
    csr_wr = 1'b0; csr_priv = 1'b1;
  endtask

  // scoreboard monitor: compare read data between edges
  always @(negedge clk) begin
    if (pend && sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      pend = 0;
      chk(csr_rdata == it.exp, it.tag, csr_rdata, it.exp);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; zone_req = 1'b0; csr_priv = 1'b1; csr_wr = 1'b0;
    csr_addr = '0; csr_wdata = '0; n_req = 1'b0; n_addr = '0;
    pwr_good = 1'b0; n_good = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;

    // R10 reset state
    chk(pwr_en == 1'b0, "R10 pwr_en", W'(pwr_en), 0);
    chk(zone_rdy == 1'b0, "R10 zone_rdy", W'(zone_rdy), 0);
    do_read(2'd0, 1'b1, 0, "R10 count");
    do_read(2'd1, 1'b1, 10000, "R10 threshold");
    do_read(2'd2, 1'b1, 0, "R10 snapshot");
    do_read(2'd3, 1'b1, 0, "R10 addr3");

    // first wake by hardware
    zone_req = 1'b1;
    tick();
    chk(pwr_en == 1'b1, "R7 wake", W'(pwr_en), 1);
    chk(zone_rdy == 1'b0, "R9 stall", W'(zone_rdy), 0);
    while (!zone_rdy) tick();
    chk(pwr_good == 1'b1, "R9 ready with good", W'(pwr_good), 1);

    // R3 strict compare against threshold 5
    do_write(2'd1, 5, 1'b1);
    tick();                       // edge k: count cleared
    zone_req = 1'b0;
    repeat (6) tick();            // count 6, equality seen at last edge
    chk(pwr_en == 1'b1, "R3 equal keeps power", W'(pwr_en), 1);
    do_read(2'd0, 1'b1, 6, "R1 idle count");
    chk(pwr_en == 1'b0, "R3 power down", W'(pwr_en), 0);

    // R12 no re-enable while supply still good
    zone_req = 1'b1;
    tick(); n = 1;
    chk(pwr_en == 1'b0, "R12 held off", W'(pwr_en), 0);
    while (!pwr_en) begin tick(); n++; end
    chk(zone_rdy == 1'b0, "R9 stall after wake", W'(zone_rdy), 0);
    while (!zone_rdy) tick();
    do_read(2'd2, 1'b1, W'(6 + n), "R8 snapshot");
    do_read(2'd0, 1'b1, 0, "R7 count cleared");

    // R11 privilege gating
    do_read(2'd1, 1'b0, 0, "R11 unpriv read");
    do_write(2'd1, 0, 1'b0);
    do_read(2'd1, 1'b1, 5, "R11 unpriv write ignored");
    chk(pwr_en == 1'b1, "R11 power unchanged", W'(pwr_en), 1);

    // R6 forced power-down by a low threshold write
    do_write(2'd1, 10000, 1'b1);
    zone_req = 1'b0;
    repeat (20) tick();
    chk(pwr_en == 1'b1, "R6 idle below threshold", W'(pwr_en), 1);
    do_write(2'd1, 3, 1'b1);
    chk(pwr_en == 1'b1, "R6 write edge", W'(pwr_en), 1);
    tick();
    chk(pwr_en == 1'b0, "R6 forced off", W'(pwr_en), 0);

    // R5 zero threshold
    zone_req = 1'b1;
    while (!zone_rdy) tick();
    do_write(2'd1, 0, 1'b1);
    repeat (4) tick();
    chk(pwr_en == 1'b1, "R5 on while used", W'(pwr_en), 1);
    zone_req = 1'b0;
    tick();
    chk(pwr_en == 1'b1, "R5 first idle edge", W'(pwr_en), 1);
    tick();
    chk(pwr_en == 1'b0, "R5 second idle edge", W'(pwr_en), 0);

    // R2 / R4 on the narrow instance with an all-ones threshold
    n_req = 1'b1;
    while (!n_rdy) tick();
    n_req = 1'b0;
    repeat (300) tick();
    n_addr = 2'd0;
    #1;
    chk(n_rdata == 8'hFF, "R2 saturated count", W'(n_rdata), 255);
    chk(n_en == 1'b1, "R4 forced on", W'(n_en), 1);

    repeat (2) tick();
    finish_run();
  end

endmodule